// File: doc/BRIEF.md
# Block and Segment Address Translator

This block is the first stage of address translation for a 32-bit processor. Each lookup takes a 32-bit effective address. The address is compared in parallel against a small file of block-translation entries. Each entry describes one naturally aligned region of between 128KB and 256MB, and the regions have a fixed power-of-two size.

When an entry matches, the block returns a 32-bit physical address and that region's attribute bits. Segment translation is skipped in that case. When no entry matches, the top four address bits select one of sixteen segment registers. The segment's 24-bit identifier is then joined to the remaining 28 address bits to form a 52-bit virtual address, which a later page-table stage consumes.

A configuration port writes and reads back the segment registers and the block entries. Each response appears exactly one clock after its request.

Top module: `ea_xlate`

## Requirements
- R1: `rsp_valid` is high in the cycle after a cycle with `req_valid` high, and low otherwise. It is low after reset.
- R2: A block entry matches when its valid bit is set and EA[31:17] equals its effective base in every bit position not covered by the size mask. The size mask occupies the low bits of the 15-bit base. A mask of 0 gives a 128KB region, and a mask of 0x7FF gives a 256MB region. Each mask is a run of ones starting at bit 0.
- R3: On a hit, `rsp_pa[31:17]` takes the physical base in the unmasked positions and EA bits in the masked positions. `rsp_pa[16:0]` equals EA[16:0].
- R4: On a hit, `rsp_attr` carries the attribute bits of the matching entry and `rsp_blk_idx` carries its index.
- R5: When several entries match, the entry with the lowest index is the one reported.
- R6: When no entry matches, `rsp_blk_hit` is 0 and `rsp_va` = {segment register EA[31:28] VSID (24 bits), EA[27:12], EA[11:0]}.
- R7: Configuration space 0 addresses the segment register `cfg_idx`. The VSID is in data bits [23:0]. A read returns it one cycle after `cfg_rd`, with `cfg_rvalid` high and bits [31:24] zero.
- R8: Space 1 is block word A: base in bits [31:17], mask in bits [12:2], valid in bit 0. Space 2 is block word B: physical base in bits [31:17], attributes in bits [3:0]. Reads return the stored fields in these positions and zero in all other bits.
- R9: An entry whose valid bit is clear never matches, and reset clears every valid bit.
- R10: On a miss, `rsp_pa` and `rsp_attr` are zero. On a hit, `rsp_va` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_space | input | 2 | 0 segment, 1 block word A, 2 block word B |
| cfg_idx | input | 4 | Register index |
| cfg_wdata | input | 32 | Write data |
| cfg_rvalid | output | 1 | Read data valid |
| cfg_rdata | output | 32 | Read data |
| req_valid | input | 1 | Lookup request |
| req_ea | input | 32 | Effective address |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_blk_hit | output | 1 | A block entry matched |
| rsp_blk_idx | output | BI_W | Index of the matching entry |
| rsp_pa | output | 32 | Physical address on a hit |
| rsp_attr | output | 4 | Attributes on a hit |
| rsp_va | output | 52 | Virtual address on a miss |

## Verification
The bench sweeps the size mask through all twelve region sizes. For each size it probes the last byte inside the region and the first byte past it. A design that decoded the mask one bit wrong would either reach past the boundary or give up the region's top half.

Overlapping entries are checked under two conditions: with the lower-numbered entry enabled, and again after it has been invalidated. A wrong priority order, or a match that ignores the valid bit, would report the wrong index or physical base.

Every segment register is exercised by misses whose offset bits vary. A swapped or shifted field in the virtual address would show up as a wrong VSID or a wrong page index. Segment rewrites after earlier lookups are also checked, to catch stale read data.

// File: rtl/ea_xlate_pkg.sv
`timescale 1ns/1ps
package ea_xlate_pkg;
  parameter int EA_W      = 32;
  parameter int BN_LSB    = 17;               // 128KB granule
  parameter int BN_W      = EA_W - BN_LSB;    // block number width
  parameter int MASK_W    = 11;               // up to 256MB
  parameter int ATTR_W    = 4;
  parameter int VSID_W    = 24;
  parameter int SEG_CNT   = 16;
  parameter int SEG_SEL_W = $clog2(SEG_CNT);
  parameter int VA_W      = VSID_W + EA_W - SEG_SEL_W;

  typedef enum logic [1:0] {
    SP_SEG   = 2'd0,
    SP_BLK_A = 2'd1,
    SP_BLK_B = 2'd2,
    SP_NONE  = 2'd3
  } cfg_space_e;

  typedef struct packed {
    logic              valid;
    logic [BN_W-1:0]   ebase;
    logic [MASK_W-1:0] mask;
    logic [BN_W-1:0]   pbase;
    logic [ATTR_W-1:0] attr;
  } blk_ent_t;
endpackage

// File: rtl/ea_seg_file.sv
`timescale 1ns/1ps
module ea_seg_file #(
  parameter int SEG_CNT = 16,
  parameter int VSID_W  = 24,
  localparam int SA_W   = $clog2(SEG_CNT)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [SA_W-1:0]   waddr,
  input  logic [VSID_W-1:0] wdata,
  input  logic              lk_en,
  input  logic [SA_W-1:0]   lk_addr,
  output logic [VSID_W-1:0] lk_vsid,
  input  logic              rd_en,
  input  logic [SA_W-1:0]   rd_addr,
  output logic [VSID_W-1:0] rd_vsid
);
  logic [VSID_W-1:0] mem [SEG_CNT];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Lookup and configuration reads are both synchronous (read-before-write)
  always_ff @(posedge clk) begin
    if (lk_en) lk_vsid <= mem[lk_addr];
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_vsid <= mem[rd_addr];
  end
endmodule

// File: rtl/ea_blk_file.sv
`timescale 1ns/1ps
module ea_blk_file
  import ea_xlate_pkg::*;
#(
  parameter int NUM_BLK = 4,
  localparam int BI_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_a,
  input  logic              we_b,
  input  logic [BI_W-1:0]   widx,
  input  logic [EA_W-1:0]   wdata,
  input  logic [BN_W-1:0]   lk_bn,
  output logic              lk_hit,
  output logic [BI_W-1:0]   lk_idx,
  output logic [BN_W-1:0]   lk_pbn,
  output logic [ATTR_W-1:0] lk_attr,
  input  logic [BI_W-1:0]   rd_idx,
  input  logic              rd_word_b,
  output logic [EA_W-1:0]   rd_data
);
  localparam int PAD_A = BN_LSB - MASK_W - 2;
  localparam int PAD_B = BN_LSB - ATTR_W;

  blk_ent_t ents [NUM_BLK];
  logic [NUM_BLK-1:0] match;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_BLK; i++) ents[i] <= '0;
    end else begin
      if (we_a) begin
        ents[widx].ebase <= wdata[EA_W-1:BN_LSB];
        ents[widx].mask  <= wdata[MASK_W+1:2];
        ents[widx].valid <= wdata[0];
      end
      if (we_b) begin
        ents[widx].pbase <= wdata[EA_W-1:BN_LSB];
        ents[widx].attr  <= wdata[ATTR_W-1:0];
      end
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{wdata[BN_LSB-1:MASK_W+2], wdata[1]};

  // One comparator per entry; mask bits are don't-care positions
  for (genvar g = 0; g < NUM_BLK; g++) begin : g_match
    logic [BN_W-1:0] care;
    assign care     = ~{{(BN_W-MASK_W){1'b0}}, ents[g].mask};
    assign match[g] = ents[g].valid && (((lk_bn ^ ents[g].ebase) & care) == '0);
  end

  // Lowest index wins
  always_comb begin
    lk_hit = 1'b0;
    lk_idx = '0;
    for (int i = NUM_BLK - 1; i >= 0; i--) begin
      if (match[i]) begin
        lk_hit = 1'b1;
        lk_idx = BI_W'(i);
      end
    end
  end

  logic [BN_W-1:0] sel_keep;
  assign sel_keep = {{(BN_W-MASK_W){1'b0}}, ents[lk_idx].mask};
  assign lk_pbn   = (ents[lk_idx].pbase & ~sel_keep) | (lk_bn & sel_keep);
  assign lk_attr  = ents[lk_idx].attr;

  always_comb begin
    if (rd_word_b)
      rd_data = {ents[rd_idx].pbase, {PAD_B{1'b0}}, ents[rd_idx].attr};
    else
      rd_data = {ents[rd_idx].ebase, {PAD_A{1'b0}}, ents[rd_idx].mask,
                 1'b0, ents[rd_idx].valid};
  end

  // An entry just invalidated must not be reported as the match
  assert_invalid_no_hit_R9: assert property (@(posedge clk) disable iff (rst)
    (we_a && !wdata[0]) |=> !(lk_hit && lk_idx == $past(widx)));
endmodule

// File: rtl/ea_xlate.sv
`timescale 1ns/1ps
module ea_xlate
  import ea_xlate_pkg::*;
#(
  parameter int NUM_BLK = 4,
  localparam int BI_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_wr,
  input  logic                 cfg_rd,
  input  logic [1:0]           cfg_space,
  input  logic [SEG_SEL_W-1:0] cfg_idx,
  input  logic [EA_W-1:0]      cfg_wdata,
  output logic                 cfg_rvalid,
  output logic [EA_W-1:0]      cfg_rdata,
  input  logic                 req_valid,
  input  logic [EA_W-1:0]      req_ea,
  output logic                 rsp_valid,
  output logic                 rsp_blk_hit,
  output logic [BI_W-1:0]      rsp_blk_idx,
  output logic [EA_W-1:0]      rsp_pa,
  output logic [ATTR_W-1:0]    rsp_attr,
  output logic [VA_W-1:0]      rsp_va
);
  localparam int LOW_W = EA_W - SEG_SEL_W;

  cfg_space_e space;
  logic       blk_ok;
  assign space  = cfg_space_e'(cfg_space);
  assign blk_ok = (int'(cfg_idx) < NUM_BLK);

  // Segment registers
  logic [VSID_W-1:0] seg_lk_vsid, seg_rd_vsid;
  ea_seg_file #(.SEG_CNT(SEG_CNT), .VSID_W(VSID_W)) u_seg (
    .clk     (clk),
    .we      (cfg_wr && space == SP_SEG),
    .waddr   (cfg_idx),
    .wdata   (cfg_wdata[VSID_W-1:0]),
    .lk_en   (req_valid),
    .lk_addr (req_ea[EA_W-1 -: SEG_SEL_W]),
    .lk_vsid (seg_lk_vsid),
    .rd_en   (cfg_rd && space == SP_SEG),
    .rd_addr (cfg_idx),
    .rd_vsid (seg_rd_vsid)
  );

  // Block entries
  logic              blk_hit;
  logic [BI_W-1:0]   blk_idx;
  logic [BN_W-1:0]   blk_pbn;
  logic [ATTR_W-1:0] blk_attr;
  logic [EA_W-1:0]   blk_rd_data;
  logic [BI_W-1:0]   blk_sel;
  assign blk_sel = cfg_idx[BI_W-1:0];

  ea_blk_file #(.NUM_BLK(NUM_BLK)) u_blk (
    .clk       (clk),
    .rst       (rst),
    .we_a      (cfg_wr && blk_ok && space == SP_BLK_A),
    .we_b      (cfg_wr && blk_ok && space == SP_BLK_B),
    .widx      (blk_sel),
    .wdata     (cfg_wdata),
    .lk_bn     (req_ea[EA_W-1:BN_LSB]),
    .lk_hit    (blk_hit),
    .lk_idx    (blk_idx),
    .lk_pbn    (blk_pbn),
    .lk_attr   (blk_attr),
    .rd_idx    (blk_sel),
    .rd_word_b (space == SP_BLK_B),
    .rd_data   (blk_rd_data)
  );

  logic unused_idx;
  assign unused_idx = ^cfg_idx;

  // Configuration readback
  logic            rd_seg_q;
  logic [EA_W-1:0] blk_rd_q;
  always_ff @(posedge clk) begin
    if (rst) cfg_rvalid <= 1'b0;
    else     cfg_rvalid <= cfg_rd;
    if (cfg_rd) begin
      rd_seg_q <= (space == SP_SEG);
      blk_rd_q <= (blk_ok && (space == SP_BLK_A || space == SP_BLK_B))
                  ? blk_rd_data : '0;
    end
  end
  assign cfg_rdata = rd_seg_q ? {{(EA_W-VSID_W){1'b0}}, seg_rd_vsid} : blk_rd_q;

  // Lookup response
  logic             hit_q;
  logic [LOW_W-1:0] ea_low_q;
  always_ff @(posedge clk) begin
    if (rst) rsp_valid <= 1'b0;
    else     rsp_valid <= req_valid;
    if (req_valid) begin
      hit_q       <= blk_hit;
      rsp_blk_idx <= blk_idx;
      rsp_pa      <= blk_hit ? {blk_pbn, req_ea[BN_LSB-1:0]} : '0;
      rsp_attr    <= blk_hit ? blk_attr : '0;
      ea_low_q    <= req_ea[LOW_W-1:0];
    end
  end
  assign rsp_blk_hit = hit_q;
  assign rsp_va      = hit_q ? '0 : {seg_lk_vsid, ea_low_q};

  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_rsp_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  assert_hit_offset_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (!rsp_blk_hit || rsp_pa[BN_LSB-1:0] == $past(req_ea[BN_LSB-1:0])));
  assert_miss_va_R6: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_blk_hit ||
                   (rsp_va[LOW_W-1:0] == $past(req_ea[LOW_W-1:0]) && rsp_pa == '0)));
  assert_cfg_read_R7: assert property (@(posedge clk) disable iff (rst)
    cfg_rd |=> cfg_rvalid);
endmodule

// File: tb/ea_xlate_test.sv
`timescale 1ns/1ps
module ea_xlate_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [1:0]  cfg_space = 2'd0;
  logic [3:0]  cfg_idx = 4'd0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_rvalid;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_ea = '0;
  logic        rsp_valid, rsp_blk_hit;
  logic [1:0]  rsp_blk_idx;
  logic [31:0] rsp_pa;
  logic [3:0]  rsp_attr;
  logic [51:0] rsp_va;

  int checks = 0, fails = 0;
  bit done = 0;

  // Bench-side model of the configured state
  logic        m_valid [4];
  logic [14:0] m_ebase [4];
  logic [10:0] m_mask  [4];
  logic [14:0] m_pbase [4];
  logic [3:0]  m_attr  [4];
  logic [23:0] m_vsid  [16];

  ea_xlate #(.NUM_BLK(4)) uut (.*);

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sp, input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_space = sp; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] sp, input logic [3:0] idx, output logic [31:0] d);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_space = sp; cfg_idx = idx;
    @(negedge clk);
    cfg_rd = 1'b0;
    check("R7 cfg_rvalid", {63'd0, cfg_rvalid}, 64'd1);
    d = cfg_rdata;
  endtask

  function automatic logic [31:0] word_a(input int i);
    return {m_ebase[i], 4'b0, m_mask[i], 1'b0, m_valid[i]};
  endfunction
  function automatic logic [31:0] word_b(input int i);
    return {m_pbase[i], 13'b0, m_attr[i]};
  endfunction

  task automatic set_blk(input int i, input logic v, input logic [14:0] eb,
                         input logic [10:0] mk, input logic [14:0] pb, input logic [3:0] at);
    m_valid[i] = v; m_ebase[i] = eb; m_mask[i] = mk; m_pbase[i] = pb; m_attr[i] = at;
    cfg_write(2'd2, 4'(i), word_b(i));
    cfg_write(2'd1, 4'(i), word_a(i));
  endtask

  task automatic lookup(input logic [31:0] ea, input int exp_idx_force);
    logic hit; logic [1:0] idx; logic [31:0] pa; logic [3:0] at; logic [51:0] va;
    logic [14:0] bn, km;
    hit = 1'b0; idx = '0; pa = '0; at = '0;
    bn = ea[31:17];
    for (int i = 3; i >= 0; i--) begin
      km = {4'b0, m_mask[i]};
      if (m_valid[i] && ((bn & ~km) == (m_ebase[i] & ~km))) begin
        hit = 1'b1; idx = 2'(i);
        pa = {(m_pbase[i] & ~km) | (bn & km), ea[16:0]};
        at = m_attr[i];
      end
    end
    va = hit ? '0 : {m_vsid[ea[31:28]], ea[27:0]};
    if (exp_idx_force >= 0) check("R5 forced index", {63'd0, hit}, 64'd1);
    @(negedge clk);
    req_valid = 1'b1; req_ea = ea;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 rsp_valid", {63'd0, rsp_valid}, 64'd1);
    check("R2 R6 hit", {63'd0, rsp_blk_hit}, {63'd0, hit});
    if (hit) begin
      check("R4 R5 index", {62'd0, rsp_blk_idx}, {62'd0, idx});
      if (exp_idx_force >= 0) check("R5 lowest wins", {62'd0, rsp_blk_idx}, 64'(exp_idx_force));
    end
    check("R3 R10 pa", {32'd0, rsp_pa}, {32'd0, pa});
    check("R4 R10 attr", {60'd0, rsp_attr}, {60'd0, at});
    check("R6 R10 va", {12'd0, rsp_va}, {12'd0, va});
    @(negedge clk);
    check("R1 idle", {63'd0, rsp_valid}, 64'd0);
  endtask

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 4; i++) begin
      m_valid[i] = 0; m_ebase[i] = '0; m_mask[i] = '0; m_pbase[i] = '0; m_attr[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
    check("R7 reset cfg_rvalid", {63'd0, cfg_rvalid}, 64'd0);

    // R7: program and read back every segment register
    for (int s = 0; s < 16; s++) begin
      m_vsid[s] = 24'(s * 24'h0F0F1) ^ 24'hA5C300;
      cfg_write(2'd0, 4'(s), {8'hFF, m_vsid[s]});
    end
    for (int s = 0; s < 16; s++) begin
      cfg_read(2'd0, 4'(s), d);
      check("R7 segment readback", {32'd0, d}, {40'd0, m_vsid[s]});
    end

    // R9: after reset no block entry is valid
    for (int i = 0; i < 4; i++) begin
      cfg_read(2'd1, 4'(i), d);
      check("R9 reset valid clear", {32'd0, d}, 64'd0);
    end

    // R6 sweep: every segment, varied offsets
    for (int s = 0; s < 16; s++)
      for (int k = 0; k < 3; k++)
        lookup({4'(s), 28'(k * 28'h0123457 + s * 28'h0000F31)}, -1);

    // R2 R3: 128KB region at 0x2468_0000
    set_blk(2, 1'b1, 15'h1234, 11'h000, 15'h2B3C, 4'h9);
    lookup(32'h2468_0000, -1);
    lookup(32'h2469_FFFF, -1);
    lookup(32'h246A_0000, -1);
    lookup(32'h2467_FFFF, -1);

    // R2 R3: 256MB region covering 0xA
    set_blk(1, 1'b1, 15'h5000, 11'h7FF, 15'h1800, 4'h5);
    lookup(32'hA000_0000, -1);
    lookup(32'hA123_4567, -1);
    lookup(32'hAFFF_FFFF, -1);
    lookup(32'hB000_0000, -1);
    lookup(32'h9FFF_FFFF, -1);

    // R8 readback of both words
    for (int i = 1; i < 3; i++) begin
      cfg_read(2'd1, 4'(i), d);
      check("R8 word A", {32'd0, d}, {32'd0, word_a(i)});
      cfg_read(2'd2, 4'(i), d);
      check("R8 word B", {32'd0, d}, {32'd0, word_b(i)});
    end

    // R5: entry 0 (2MB) nested inside entry 1
    set_blk(0, 1'b1, 15'h5200, 11'h00F, 15'h7F00, 4'hC);
    lookup(32'hA400_1234, 0);
    lookup(32'hA600_0000, 1);
    // R5: entry 3 duplicates entry 2
    set_blk(3, 1'b1, 15'h1234, 11'h000, 15'h0077, 4'h3);
    lookup(32'h2468_8888, 2);
    // R9: invalidated entry loses, entry 1 takes over
    set_blk(0, 1'b0, 15'h5200, 11'h00F, 15'h7F00, 4'hC);
    lookup(32'hA400_1234, 1);
    set_blk(2, 1'b0, 15'h1234, 11'h000, 15'h2B3C, 4'h9);
    lookup(32'h2468_8888, 3);

    // R2 size sweep at 0x3000_0000: last byte inside, first byte past
    for (int m = 0; m < 12; m++) begin
      set_blk(3, 1'b1, 15'h1800, 11'((1 << m) - 1), 15'h7FFF, 4'(m));
      lookup(32'h3000_0000 + 32'((64'd1 << (17 + m)) - 1), -1);
      lookup(32'h3000_0000 + 32'(64'd1 << (17 + m)), -1);
    end

    // R6: segment rewrite is seen by the next miss
    m_vsid[5] = 24'h13579B;
    cfg_write(2'd0, 4'd5, {8'h00, m_vsid[5]});
    lookup(32'h5ABC_DEF0, -1);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule